// File: doc/BRIEF.md
# HDLC FIFO Watermark Status Logic

This block holds the transmit and receive byte FIFOs of one HDLC channel and reports their fill state through two live watermark flags. The host loads the transmit FIFO and drains the receive FIFO. The serial side does the opposite: it pops transmit bytes and pushes received bytes. One control byte carries two 3-bit codes. One code sets the transmit low threshold and the other sets the receive high threshold. A code k selects a threshold of `WM_STEP*(k+1)` bytes.

The transmit flag tells the host to refill before the serializer runs dry. The receive flag tells the host to drain before received data is lost. Both flags are plain comparisons of the current level against the threshold, so they clear without any host action once the condition goes away. Each flag has an enable bit, and the enabled flags drive an active-low interrupt. A small register port gives access to the control byte, the enables and a status byte. The status byte also holds sticky error bits for a rejected transmit write and a rejected receive read.

Top module: `hdlc_fifo_wm`

## Requirements
- R1: Register address 0 holds the watermark control byte. Bits 5:3 are the transmit code and bits 2:0 are the receive code. Code k selects a threshold of WM_STEP*(k+1) bytes, and the byte reads back as written.
- R2: `tx_low_o` is 1 exactly while the transmit level is strictly below the transmit threshold. It drops by itself once the level reaches the threshold, and it rises again when the level falls back below it.
- R3: `rx_high_o` is 1 exactly while the receive level is strictly above the receive threshold. It clears by itself when the level drops to the threshold or below.
- R4: Register address 1 bit 0 enables the transmit flag and bit 1 enables the receive flag. `irq_no` is 0 exactly when at least one enabled flag is 1.
- R5: Both FIFOs keep first-in first-out order. The oldest entry is visible on the data output whenever the level is non-zero.
- R6: A transmit push while the transmit FIFO is full leaves the FIFO unchanged and sets sticky status bit 2. Status is at address 2. Writing 1 to bit 2 of address 2 clears it. Status bits 0 and 1 mirror `tx_low_o` and `rx_high_o`.
- R7: A receive pop while the receive FIFO is empty leaves it unchanged and sets sticky status bit 3. Writing 1 to bit 3 of address 2 clears it.
- R8: Control bits 7:6 ignore writes and read back as 0.
- R9: Reset empties both FIFOs, sets both codes to 0, disables both interrupt enables and clears the sticky bits. After reset, `tx_low_o`=1, `rx_high_o`=0 and `irq_no`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational on address |
| tx_push_i | input | 1 | Host write into transmit FIFO |
| tx_data_i | input | DW | Transmit write data |
| tx_pop_i | input | 1 | Serializer read from transmit FIFO |
| tx_data_o | output | DW | Oldest transmit byte |
| tx_level_o | output | LW | Transmit FIFO level |
| rx_push_i | input | 1 | Deserializer write into receive FIFO |
| rx_data_i | input | DW | Receive write data |
| rx_pop_i | input | 1 | Host read from receive FIFO |
| rx_data_o | output | DW | Oldest receive byte |
| rx_level_o | output | LW | Receive FIFO level |
| tx_low_o | output | 1 | Live transmit low-watermark flag |
| rx_high_o | output | 1 | Live receive high-watermark flag |
| irq_no | output | 1 | Interrupt, active low |

## Verification
The bench builds the block with DEPTH=16 and WM_STEP=2. With these values all eight codes map to thresholds from 2 to 16, and the top code lands exactly on the FIFO depth. This lets every code be tried against levels one below, at and one above its threshold in a few dozen cycles. It also makes a full FIFO, and so the rejected-write and sticky-bit paths, cheap to reach.

// File: rtl/hfw_pkg.sv
package hfw_pkg;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_IEN  = 2'd1,
    ADDR_STAT = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  localparam int unsigned ST_TXLOW = 0;
  localparam int unsigned ST_RXHI  = 1;
  localparam int unsigned ST_TXOVF = 2;
  localparam int unsigned ST_RXUNF = 3;
endpackage

// File: rtl/hfw_fifo.sv
module hfw_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] data_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [LW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == LW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_ptr_q];
  assign level_o = cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      cnt_q <= cnt_q + LW'(do_push) - LW'(do_pop);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LW'(DEPTH)); // R5
  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> $stable(cnt_q)); // R6
  AST_EMPTY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/hfw_wm_cmp.sv
module hfw_wm_cmp #(
  parameter int unsigned LW      = 7,
  parameter int unsigned CODE_W  = 3,
  parameter int unsigned WM_STEP = 8,
  parameter bit          BELOW   = 1'b1
) (
  input  logic [LW-1:0]     level_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [LW-1:0]     thr_o,
  output logic              flag_o
);
  assign thr_o = (LW'(code_i) + LW'(1)) * LW'(WM_STEP);

  generate
    if (BELOW) begin : g_below
      assign flag_o = (level_i < thr_o);
    end else begin : g_above
      assign flag_o = (level_i > thr_o);
    end
  endgenerate
endmodule

// File: rtl/hdlc_fifo_wm.sv
module hdlc_fifo_wm
  import hfw_pkg::*;
#(
  parameter int unsigned DW      = 8,
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned WM_STEP = 8,
  localparam int unsigned LW     = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [7:0]    reg_wdata_i,
  output logic [7:0]    reg_rdata_o,
  input  logic          tx_push_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          tx_pop_i,
  output logic [DW-1:0] tx_data_o,
  output logic [LW-1:0] tx_level_o,
  input  logic          rx_push_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_pop_i,
  output logic [DW-1:0] rx_data_o,
  output logic [LW-1:0] rx_level_o,
  output logic          tx_low_o,
  output logic          rx_high_o,
  output logic          irq_no
);
  logic [CODE_W-1:0] tx_code_q, rx_code_q;
  logic [1:0]        ien_q;
  logic              tx_ovf_q, rx_unf_q;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [LW-1:0]     tx_thr, rx_thr;
  logic              wr_ctrl, wr_ien, wr_stat;

  assign wr_ctrl = reg_we_i && (reg_addr_i == ADDR_CTRL);
  assign wr_ien  = reg_we_i && (reg_addr_i == ADDR_IEN);
  assign wr_stat = reg_we_i && (reg_addr_i == ADDR_STAT);

  hfw_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i(tx_push_i), .data_i(tx_data_i), .pop_i(tx_pop_i),
    .data_o(tx_data_o), .level_o(tx_level_o),
    .full_o(tx_full), .empty_o(tx_empty)
  );

  hfw_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i(rx_push_i), .data_i(rx_data_i), .pop_i(rx_pop_i),
    .data_o(rx_data_o), .level_o(rx_level_o),
    .full_o(rx_full), .empty_o(rx_empty)
  );

  hfw_wm_cmp #(.LW(LW), .CODE_W(CODE_W), .WM_STEP(WM_STEP), .BELOW(1'b1)) u_tx_cmp (
    .level_i(tx_level_o), .code_i(tx_code_q), .thr_o(tx_thr), .flag_o(tx_low_o)
  );

  hfw_wm_cmp #(.LW(LW), .CODE_W(CODE_W), .WM_STEP(WM_STEP), .BELOW(1'b0)) u_rx_cmp (
    .level_i(rx_level_o), .code_i(rx_code_q), .thr_o(rx_thr), .flag_o(rx_high_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_code_q <= '0;
      rx_code_q <= '0;
      ien_q     <= '0;
      tx_ovf_q  <= 1'b0;
      rx_unf_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        tx_code_q <= reg_wdata_i[5:3];
        rx_code_q <= reg_wdata_i[2:0];
      end
      if (wr_ien) ien_q <= reg_wdata_i[1:0];
      // set wins over write-one-to-clear in the same cycle
      if (tx_push_i && tx_full)               tx_ovf_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[ST_TXOVF]) tx_ovf_q <= 1'b0;
      if (rx_pop_i && rx_empty)               rx_unf_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[ST_RXUNF]) rx_unf_q <= 1'b0;
    end
  end

  assign irq_no = !((tx_low_o && ien_q[0]) || (rx_high_o && ien_q[1]));

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_CTRL: reg_rdata_o = {2'b00, tx_code_q, rx_code_q};
      ADDR_IEN:  reg_rdata_o = {6'b0, ien_q};
      ADDR_STAT: reg_rdata_o = {4'b0, rx_unf_q, tx_ovf_q, rx_high_o, tx_low_o};
      default:   reg_rdata_o = '0;
    endcase
  end

  AST_TXLOW_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_level_o >= tx_thr) |-> !tx_low_o); // R2
  AST_RXHI_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_level_o <= rx_thr) |-> !rx_high_o); // R3
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == 2'b00) |-> irq_no); // R4
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ovf_q && !wr_stat) |=> tx_ovf_q); // R6
  AST_UNF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_unf_q && !wr_stat) |=> rx_unf_q); // R7
  AST_CTRL_TOP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_CTRL) |-> (reg_rdata_o[7:6] == 2'b00)); // R8
endmodule

// File: tb/sim_hdlc_fifo_wm.sv
module sim_hdlc_fifo_wm;
  localparam int DW = 8, DEPTH = 16, STEP = 2, LW = 5;
  localparam time CLK_P = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
  logic [DW-1:0] tx_din = '0, rx_din = '0, tx_dout, rx_dout;
  logic [LW-1:0] tx_lvl, rx_lvl;
  logic tx_low, rx_high, irq_n;
  int n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  hdlc_fifo_wm #(.DW(DW), .DEPTH(DEPTH), .WM_STEP(STEP)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .tx_push_i(tx_push), .tx_data_i(tx_din), .tx_pop_i(tx_pop),
    .tx_data_o(tx_dout), .tx_level_o(tx_lvl),
    .rx_push_i(rx_push), .rx_data_i(rx_din), .rx_pop_i(rx_pop),
    .rx_data_o(rx_dout), .rx_level_o(rx_lvl),
    .tx_low_o(tx_low), .rx_high_o(rx_high), .irq_no(irq_n)
  );

  // {tx_code, rx_code, tx_fill, rx_fill, exp_tx_low, exp_rx_high}
  localparam logic [17:0] VEC [8] = '{
    {3'd0, 3'd0, 5'd1,  5'd2,  1'b1, 1'b0},
    {3'd0, 3'd0, 5'd2,  5'd3,  1'b0, 1'b1},
    {3'd3, 3'd5, 5'd7,  5'd12, 1'b1, 1'b0},
    {3'd3, 3'd5, 5'd8,  5'd13, 1'b0, 1'b1},
    {3'd7, 3'd7, 5'd15, 5'd16, 1'b1, 1'b0},
    {3'd7, 3'd7, 5'd16, 5'd16, 1'b0, 1'b0},
    {3'd5, 3'd1, 5'd0,  5'd5,  1'b1, 1'b1},
    {3'd1, 3'd6, 5'd10, 5'd0,  1'b0, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic push_tx(input logic [7:0] d);
    @(negedge clk); tx_push = 1'b1; tx_din = d;
    @(negedge clk); tx_push = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] d);
    @(negedge clk); rx_push = 1'b1; rx_din = d;
    @(negedge clk); rx_push = 1'b0;
  endtask

  task automatic pop_tx();
    @(negedge clk); tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  task automatic pop_rx();
    @(negedge clk); rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    do_reset();

    // R9 reset state
    chk("R9 tx_low", tx_low, 1);
    chk("R9 rx_high", rx_high, 0);
    chk("R9 irq_n", irq_n, 1);
    chk("R9 levels", {tx_lvl, rx_lvl}, 0);
    rd(2'd0, r); chk("R9 ctrl", r, 0);
    rd(2'd1, r); chk("R9 ien", r, 0);
    rd(2'd2, r); chk("R9 status", r, 8'h01);

    // table: thresholds per code, both flags, irq (R1 R2 R3 R4)
    for (int i = 0; i < 8; i++) begin
      do_reset();
      wr(2'd0, {2'b00, VEC[i][17:15], VEC[i][14:12]});
      wr(2'd1, 8'h03);
      for (int j = 0; j < int'(VEC[i][11:7]); j++) push_tx(8'(j));
      for (int j = 0; j < int'(VEC[i][6:2]); j++) push_rx(8'(j));
      chk($sformatf("R2 vec%0d tx_low", i), tx_low, VEC[i][1]);
      chk($sformatf("R3 vec%0d rx_high", i), rx_high, VEC[i][0]);
      chk($sformatf("R4 vec%0d irq_n", i), irq_n, !(VEC[i][1] || VEC[i][0]));
    end

    // R1 readback
    do_reset();
    wr(2'd0, 8'h2B);
    rd(2'd0, r); chk("R1 ctrl readback", r, 8'h2B);
    // R8 upper bits
    wr(2'd0, 8'hFF);
    rd(2'd0, r); chk("R8 ctrl top bits", r, 8'h3F);

    // R2 real-time behaviour, threshold 4
    do_reset();
    wr(2'd0, 8'h08);
    repeat (3) push_tx(8'h11);
    chk("R2 below", tx_low, 1);
    push_tx(8'h11);
    chk("R2 at threshold", tx_low, 0);
    pop_tx();
    chk("R2 falls back", tx_low, 1);

    // R3 real-time, threshold 2
    do_reset();
    repeat (3) push_rx(8'h22);
    chk("R3 above", rx_high, 1);
    rd(2'd2, r); chk("R6 status mirror", r[1:0], 2'b11);
    pop_rx();
    chk("R3 back to threshold", rx_high, 0);

    // R4 enable gating
    do_reset();
    chk("R4 disabled", irq_n, 1);
    wr(2'd1, 8'h01);
    chk("R4 tx enabled", irq_n, 0);
    wr(2'd1, 8'h02);
    chk("R4 rx enabled no flag", irq_n, 1);
    repeat (3) push_rx(8'h33);
    chk("R4 rx flag", irq_n, 0);

    // R5 order
    do_reset();
    push_rx(8'hA5); push_rx(8'h3C); push_rx(8'h7E);
    chk("R5 rx first", rx_dout, 8'hA5);
    pop_rx();
    chk("R5 rx second", rx_dout, 8'h3C);
    pop_rx();
    chk("R5 rx third", rx_dout, 8'h7E);
    push_tx(8'h5A); push_tx(8'hC3);
    chk("R5 tx first", tx_dout, 8'h5A);
    pop_tx();
    chk("R5 tx second", tx_dout, 8'hC3);

    // R6 overflow
    do_reset();
    for (int j = 0; j < DEPTH; j++) push_tx(8'(j + 1));
    push_tx(8'hEE);
    chk("R6 level held", tx_lvl, DEPTH);
    chk("R6 head kept", tx_dout, 8'h01);
    rd(2'd2, r); chk("R6 sticky set", r, 8'h04);
    wr(2'd2, 8'h04);
    rd(2'd2, r); chk("R6 cleared", r, 8'h00);

    // R7 underflow
    pop_rx();
    chk("R7 level held", rx_lvl, 0);
    rd(2'd2, r); chk("R7 sticky set", r, 8'h08);
    pop_tx();
    rd(2'd2, r); chk("R7 stays set", r, 8'h08);
    wr(2'd2, 8'h08);
    rd(2'd2, r); chk("R7 cleared", r, 8'h00);

    // R9 reset after activity
    wr(2'd1, 8'h03);
    do_reset();
    chk("R9 tx emptied", tx_lvl, 0);
    rd(2'd1, r); chk("R9 ien cleared", r, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule